// File: doc/BRIEF.md
# Pipelined Priority Argmax With Result Lookup

This block accepts a vector of 64 unsigned priority values on any clock cycle and finds the position of the largest one. The search is a binary reduction: each level compares neighbouring pairs and keeps the larger value together with the position it came from, so each level halves the number of candidates. Six levels reduce 64 candidates to one. A register stage follows every second level, so each pipeline stage holds two comparators in series. A new vector can enter on every cycle.

The winning position then addresses a 64-entry result table. The table's registered output is the block's main result, and the winning position and priority are returned with it. Valid flags travel through the pipeline alongside the data. The interface has no ready signal, so the consumer must take every result on the cycle it appears. The table is loaded through a separate write port. Writes to the table never stall or disturb the search pipeline.

Top module: `argmax_lookup`

## Requirements
- R1: While reset is held, and after reset until a vector is accepted, `outValid` is 0.
- R2: A vector sampled with `inValid` = 1 at rising edge k produces exactly one result, with `outValid` = 1, right after edge k+3. Vectors on consecutive cycles give results on consecutive cycles, in the same order. A cycle without `inValid` gives no result.
- R3: `outIdx` is the position of the largest priority in the vector. Item j occupies bits [j*PRIO_W +: PRIO_W] of `inPrio`. `outPrio` is that largest priority.
- R4: When several items share the largest priority, the lowest-numbered of them is reported.
- R5: `outData` equals the table entry addressed by `outIdx`.
- R6: A table write at address a (where `cfgWe` = 1) takes effect at the next rising edge. A result read at that same edge returns the entry's previous content. Later reads return the new content.
- R7: Table writes do not change `outValid`, `outIdx`, `outPrio` or `outData` on cycles when no result is produced.
- R8: On cycles without a new result, `outIdx`, `outPrio` and `outData` keep their previous values.
- R9: Priorities compare as unsigned numbers, so 0xFF beats 0x7F and 0x80 beats 0x7F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the valid pipeline |
| inValid | input | 1 | Pushes `inPrio` into the pipeline this cycle |
| inPrio | input | 64*PRIO_W | Packed priorities, item j at bits [j*PRIO_W +: PRIO_W] |
| cfgWe | input | 1 | Result table write strobe |
| cfgAddr | input | 6 | Result table write address |
| cfgData | input | RES_W | Result table write data |
| outValid | output | 1 | Result present this cycle |
| outIdx | output | 6 | Position of the winning item |
| outPrio | output | PRIO_W | Priority of the winning item |
| outData | output | RES_W | Result table entry at the winning position |

## Verification
Each result is due right after the fourth rising edge, counting the edge that samples the vector. The driver stamps every expected result with the cycle count at push plus four. The monitor compares each result it sees against the oldest stamp in the queue and reports both a late result and an early one. The case where a table write and a result read fall on the same edge is placed by counting three idle cycles after the push. Hold behaviour is checked by sampling the outputs across idle cycles that contain table writes.

// File: rtl/argmax_pkg.sv
package argmax_pkg;
  localparam int ITEMS   = 64;
  localparam int IDX_W   = $clog2(ITEMS);
  localparam int LEVELS  = IDX_W;
  localparam int STAGES  = (LEVELS + 1) / 2;
  localparam int LATENCY = STAGES + 1;

  // strobes from control to datapath
  typedef struct packed {
    logic [STAGES-1:0] stgEn;
    logic              rdEn;
  } strobe_t;
endpackage

// File: rtl/argmax_pair_level.sv
module argmax_pair_level
  import argmax_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int IN_CNT = 64
) (
  input  logic [IN_CNT*(PRIO_W+IDX_W)-1:0]     inVec,
  output logic [(IN_CNT/2)*(PRIO_W+IDX_W)-1:0] outVec
);
  localparam int EW      = PRIO_W + IDX_W;
  localparam int OUT_CNT = IN_CNT / 2;

  for (genvar k = 0; k < OUT_CNT; k++) begin : pair
    logic [EW-1:0] loSide;
    logic [EW-1:0] hiSide;
    assign loSide = inVec[(2*k)*EW +: EW];
    assign hiSide = inVec[(2*k+1)*EW +: EW];
    // strict compare: the lower-numbered side keeps ties
    assign outVec[k*EW +: EW] =
      (hiSide[EW-1:IDX_W] > loSide[EW-1:IDX_W]) ? hiSide : loSide;
  end
endmodule

// File: rtl/argmax_control.sv
module argmax_control
  import argmax_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output strobe_t stb,
  output logic    outValid
);
  logic [STAGES-1:0] vld;
  logic [STAGES-1:0] vldNext;
  logic              outQ;

  assign vldNext = (vld << 1) | STAGES'(inValid);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld  <= '0;
      outQ <= 1'b0;
    end else begin
      vld  <= vldNext;
      outQ <= vld[STAGES-1];
    end
  end

  assign stb.stgEn = vldNext;
  assign stb.rdEn  = vld[STAGES-1];
  assign outValid  = outQ;

  // R2
  latency_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##LATENCY outValid);

  // R2
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##LATENCY !outValid);
endmodule

// File: rtl/argmax_datapath.sv
module argmax_datapath
  import argmax_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int RES_W  = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   stb,
  input  logic [ITEMS*PRIO_W-1:0]   prioVec,
  input  logic                      cfgWe,
  input  logic [IDX_W-1:0]          cfgAddr,
  input  logic [RES_W-1:0]          cfgData,
  output logic [IDX_W-1:0]          outIdx,
  output logic [PRIO_W-1:0]         outPrio,
  output logic [RES_W-1:0]          outData
);
  localparam int EW = PRIO_W + IDX_W;

  for (genvar l = 0; l < LEVELS; l++) begin : lvl
    localparam int  IN_CNT  = ITEMS >> l;
    localparam int  OUT_CNT = IN_CNT / 2;
    localparam bit  IS_REG  = (l % 2 == 1) || (l == LEVELS - 1);
    localparam int  SI      = l / 2;

    logic [IN_CNT*EW-1:0]  src;
    logic [OUT_CNT*EW-1:0] red;
    logic [OUT_CNT*EW-1:0] res;

    if (l == 0) begin : seed
      for (genvar j = 0; j < ITEMS; j++) begin : tag
        assign src[j*EW +: EW] = {prioVec[j*PRIO_W +: PRIO_W], IDX_W'(j)};
      end
    end else begin : chain
      assign src = lvl[l-1].res;
    end

    argmax_pair_level #(.PRIO_W(PRIO_W), .IN_CNT(IN_CNT)) i_pair (
      .inVec (src),
      .outVec(red)
    );

    if (IS_REG) begin : pipe
      logic [OUT_CNT*EW-1:0] q;
      always_ff @(posedge clk) begin
        if (stb.stgEn[SI]) q <= red;
      end
      assign res = q;
    end else begin : comb
      assign res = red;
    end
  end

  logic [EW-1:0]      winner;
  logic [IDX_W-1:0]   winIdx;
  logic [RES_W-1:0]   table_q [ITEMS];

  assign winner = lvl[LEVELS-1].res;
  assign winIdx = winner[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (cfgWe) table_q[cfgAddr] <= cfgData;
  end

  always_ff @(posedge clk) begin
    if (stb.rdEn) begin
      outData <= table_q[winIdx];
      outIdx  <= winIdx;
      outPrio <= winner[EW-1:IDX_W];
    end
  end

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdEn |=> ($stable(outIdx) && $stable(outPrio)));

  // R7
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && !stb.rdEn) |=> $stable(outData));

  // R5
  read_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdEn && !cfgWe) |=> (outData == table_q[outIdx]));
endmodule

// File: rtl/argmax_lookup.sv
module argmax_lookup
  import argmax_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int RES_W  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [ITEMS*PRIO_W-1:0] inPrio,
  input  logic                    cfgWe,
  input  logic [IDX_W-1:0]        cfgAddr,
  input  logic [RES_W-1:0]        cfgData,
  output logic                    outValid,
  output logic [IDX_W-1:0]        outIdx,
  output logic [PRIO_W-1:0]       outPrio,
  output logic [RES_W-1:0]        outData
);
  strobe_t stb;

  argmax_control i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .stb     (stb),
    .outValid(outValid)
  );

  argmax_datapath #(.PRIO_W(PRIO_W), .RES_W(RES_W)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .prioVec(inPrio),
    .cfgWe  (cfgWe),
    .cfgAddr(cfgAddr),
    .cfgData(cfgData),
    .outIdx (outIdx),
    .outPrio(outPrio),
    .outData(outData)
  );
endmodule

// File: tb/test_argmax_lookup.sv
module test_argmax_lookup;
  import argmax_pkg::*;
  localparam int PW = 8;
  localparam int RW = 16;
  localparam int VW = ITEMS * PW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [VW-1:0] inPrio = '0;
  logic cfgWe = 1'b0;
  logic [IDX_W-1:0] cfgAddr = '0;
  logic [RW-1:0] cfgData = '0;
  logic outValid;
  logic [IDX_W-1:0] outIdx;
  logic [PW-1:0] outPrio;
  logic [RW-1:0] outData;

  argmax_lookup #(.PRIO_W(PW), .RES_W(RW)) i_argmax_lookup (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inPrio(inPrio),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .outValid(outValid), .outIdx(outIdx), .outPrio(outPrio), .outData(outData)
  );

  always #4 clk = ~clk;

  typedef struct {
    int unsigned idx;
    int unsigned prio;
    int unsigned data;
    longint      due;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  int nChk = 0;
  int nBad = 0;
  longint cyc = 0;
  logic [RW-1:0] memModel [ITEMS];
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // monitor: results compared in arrival order
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2", "result with nothing pending", 1, 0);
      end else begin
        automatic exp_t e = expQ.pop_front();
        check(cyc == e.due, "R2", "result cycle", cyc, e.due);
        check(outIdx == e.idx, e.tag, "winning index", outIdx, e.idx);
        check(outPrio == e.prio, "R3", "winning priority", outPrio, e.prio);
        check(outData == e.data, "R5", "table data", outData, e.data);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushVec(input logic [VW-1:0] v, input string tag);
    exp_t e;
    int unsigned bi = 0;
    int unsigned bp = v[PW-1:0];
    for (int j = 1; j < ITEMS; j++) begin
      if (v[j*PW +: PW] > bp) begin
        bp = v[j*PW +: PW];
        bi = j;
      end
    end
    e.idx = bi; e.prio = bp; e.data = memModel[bi];
    e.due = cyc + LATENCY; e.tag = tag;
    expQ.push_back(e);
    inValid = 1'b1;
    inPrio  = v;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic cfgWrite(input int a, input logic [RW-1:0] d);
    cfgWe = 1'b1; cfgAddr = IDX_W'(a); cfgData = d;
    memModel[a] = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "R2", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    logic [VW-1:0] v;
    logic [IDX_W-1:0] hIdx;
    logic [RW-1:0] hData;
    logic [PW-1:0] hPrio;

    // R1: reset state
    idle(3);
    check(outValid == 1'b0, "R1", "outValid in reset", outValid, 0);
    rstN = 1'b1;
    idle(2);
    check(outValid == 1'b0, "R1", "outValid after reset", outValid, 0);

    for (int a = 0; a < ITEMS; a++) cfgWrite(a, RW'(a * 977 + 321));
    idle(4);
    check(outValid == 1'b0, "R7", "table load gives no result", outValid, 0);

    // R3: single maxima at various places
    v = '0; v[63*PW +: PW] = 8'd9;  pushVec(v, "R3");
    v = '0; v[0 +: PW]     = 8'd1;  pushVec(v, "R3");
    v = '0; v[17*PW +: PW] = 8'd200; v[18*PW +: PW] = 8'd199; pushVec(v, "R3");
    for (int j = 0; j < ITEMS; j++) v[j*PW +: PW] = PW'(j); pushVec(v, "R3");
    // R4: ties
    v = {ITEMS{8'h55}}; pushVec(v, "R4");
    v = '0; v[10*PW +: PW] = 8'd77; v[40*PW +: PW] = 8'd77; pushVec(v, "R4");
    v = '0; v[62*PW +: PW] = 8'd5;  v[63*PW +: PW] = 8'd5;  pushVec(v, "R4");
    // R9: unsigned compare
    v = '0; v[3*PW +: PW] = 8'h7F; v[50*PW +: PW] = 8'hFF; pushVec(v, "R9");
    v = '0; v[2*PW +: PW] = 8'h7F; v[33*PW +: PW] = 8'h80; pushVec(v, "R9");
    idle(6);
    check(expQ.size() == 0, "R2", "directed results pending", expQ.size(), 0);

    // R8 / R7: outputs hold across idle cycles with table writes
    hIdx = outIdx; hData = outData; hPrio = outPrio;
    cfgWrite(hIdx, 16'hBEEF);
    idle(3);
    check(outData == hData, "R7", "data after idle write", outData, hData);
    check(outIdx == hIdx, "R8", "index held", outIdx, hIdx);
    check(outPrio == hPrio, "R8", "priority held", outPrio, hPrio);
    check(outValid == 1'b0, "R7", "no result from write", outValid, 0);
    v = '0; v[33*PW +: PW] = 8'hF0; pushVec(v, "R6");
    idle(5);

    // R6: write on the same edge as the read returns old content
    v = '0; v[5*PW +: PW] = 8'd99; pushVec(v, "R6");
    idle(2);
    cfgWrite(5, 16'h1234);
    idle(1);
    v = '0; v[5*PW +: PW] = 8'd98; pushVec(v, "R6");
    idle(6);

    // R2/R3/R4: back-to-back random vectors, narrow and wide ranges
    for (int n = 0; n < 300; n++) begin
      for (int j = 0; j < ITEMS; j++)
        v[j*PW +: PW] = (n % 2 == 0) ? PW'($urandom % 4) : PW'($urandom);
      pushVec(v, (n % 2 == 0) ? "R4" : "R3");
    end
    // sparse pushes with gaps
    for (int n = 0; n < 40; n++) begin
      for (int j = 0; j < ITEMS; j++) v[j*PW +: PW] = PW'($urandom);
      pushVec(v, "R3");
      idle(n % 5);
    end
    idle(8);
    check(expQ.size() == 0, "R2", "results outstanding at end", expQ.size(), 0);
    finishRun();
  end
endmodule